// File: doc/BRIEF.md
# Serial Link to Endpoint FIFO Bridge

This block sits between two byte-wide serial link ports and a slave FIFO interface that holds four endpoint buffers. Each link owns one outbound buffer, which carries data from the host to the link, and one inbound buffer, which carries data from the link to the host. The bridge picks one buffer per clock with a 2-bit address. It reads a byte from an outbound buffer only while that buffer holds data, and it writes a byte into an inbound buffer only while that buffer has room.

A route mode sets where outbound bytes go. In direct mode each link transmits its own outbound data and feeds its own inbound buffer. In loopback mode every outbound byte comes straight back into the same link's inbound buffer. In crossback mode link 0's outbound data lands in link 1's inbound buffer and link 1's outbound data lands in link 0's inbound buffer. In both internal modes the physical receivers are not used.

The host side works on packets, but the link side is a plain byte stream. To handle this, the bridge counts the bytes written into each inbound packet. It issues a commit strobe for a partly filled packet once the link has been idle for a fixed number of bit times at the selected link speed. A full packet is committed by the buffer itself, so the bridge sends no strobe for it.

Top module: `link_fifo_bridge`

## Requirements
- R1: Address 0 selects link 0's outbound buffer and address 1 selects link 1's outbound buffer. Address 2 selects link 0's inbound buffer and address 3 selects link 1's inbound buffer. `fifo_addr` is 0 in any cycle without a strobe. On a write, `fifo_wdata` carries the oldest byte held for that link.
- R2: `fifo_rd` is raised only at addresses 0 or 1, and only while that link's `flag_empty` bit is 0 (a 1 means the buffer is empty). A read also needs the byte's destination holding register to be free.
- R3: `fifo_wr` is raised only at addresses 2 or 3, and only while that link's `flag_full` bit is 0 (a 1 means the buffer is full).
- R4: At most one of `fifo_rd`, `fifo_wr` and `fifo_commit` is high in a cycle. The four addresses are served round-robin: the search starts one past the last address served and skips any address that cannot transfer.
- R5: With `route_mode` = 00 (direct), outbound bytes of link k appear on `tx_data` lane k in order. `tx_valid[k]` stays high and `tx_data` stays stable until `tx_ready[k]` is high.
- R6: With `route_mode` = 01 (loopback), every byte read from link k's outbound buffer is written to link k's inbound buffer, in order.
- R7: With `route_mode` = 1x (crossback), bytes from link 0's outbound buffer are written to link 1's inbound buffer, and bytes from link 1's outbound buffer are written to link 0's inbound buffer, in order.
- R8: In direct mode `rx_ready[k]` is high whenever link k's one-byte receive holding register is empty. In loopback and crossback `rx_ready` is 0, and `rx_valid` has no effect.
- R9: Each inbound write reloads a per-link idle timer with (BIT_TIMES × SLOW_DIV) >> `link_speed`. Settings 0 to 3 stand for the slowest to the fastest link rate. The timer counts down by one each cycle. When it reaches zero with a partly filled packet, that link's inbound address becomes eligible for a `fifo_commit` strobe.
- R10: After PKT_BYTES bytes have been written into a packet, its count restarts at zero and no commit strobe follows for it.
- R11: `fifo_commit` is never issued for a link whose current packet holds no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| route_mode | input | 2 | 00 direct, 01 loopback, 1x crossback |
| link_speed | input | 2 | Link rate setting, 0 slowest to 3 fastest |
| fifo_addr | output | 2 | Endpoint buffer select |
| fifo_rd | output | 1 | Read strobe for an outbound buffer |
| fifo_rdata | input | DW | Byte at the head of the selected outbound buffer |
| flag_empty | input | 2 | Outbound buffer empty, one bit per link |
| flag_full | input | 2 | Inbound buffer full, one bit per link |
| fifo_wr | output | 1 | Write strobe for an inbound buffer |
| fifo_wdata | output | DW | Byte written to the inbound buffer |
| fifo_commit | output | 1 | Commit the partly filled inbound packet at fifo_addr |
| tx_valid | output | 2 | Transmit byte valid per link |
| tx_data | output | 2*DW | Transmit bytes, lane k at bits k*DW |
| tx_ready | input | 2 | Link accepts the transmit byte |
| rx_valid | input | 2 | Received byte valid per link |
| rx_data | input | 2*DW | Received bytes, lane k at bits k*DW |
| rx_ready | output | 2 | Received byte accepted (acknowledge) |

## Verification
The bench builds the bridge with PKT_BYTES = 8, BIT_TIMES = 4 and SLOW_DIV = 8. This gives idle reloads of 32, 16, 8 and 4 cycles. With these values the idle commit fires at several speed settings, and a full-packet boundary is crossed within a few hundred cycles instead of thousands. Direct mode runs with irregular `tx_ready` and full-flag patterns. Loopback delivers exactly one packet of eight bytes on one link to show that no commit follows it. Crossback runs at the fastest setting, where commits fall in the middle of a stream.

// File: rtl/lfb_pkg.sv
// Shared types for the link-to-FIFO bridge.
// Assumes the 2-bit route encoding of the top-level port.
package lfb_pkg;

    typedef enum logic [1:0] {
        PATH_DIRECT = 2'b00,
        PATH_LOOP   = 2'b01,
        PATH_CROSS  = 2'b10
    } path_e;

    // Map the route_mode port code to a data path; bit 1 selects crossback.
    function automatic path_e decode_route(input logic [1:0] code);
        if (code[1])
            return PATH_CROSS;
        else if (code[0])
            return PATH_LOOP;
        else
            return PATH_DIRECT;
    endfunction

endpackage

// File: rtl/lfb_rr_pick.sv
// Round-robin picker over N request lines.
// Chooses the first asserted request at or after ptr, wrapping around.
// Purely combinational; the caller owns the pointer register.
module lfb_rr_pick #(
    parameter int N  = 4,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [AW-1:0] ptr,
    output logic          any,
    output logic [AW-1:0] pick
);

    // Walk offsets from farthest to nearest so the nearest request wins.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[(int'(ptr) + i) % N]) begin
                any  = 1'b1;
                pick = AW'((int'(ptr) + i) % N);
            end
        end
    end

endmodule

// File: rtl/lfb_in_lane.sv
// Inbound lane for one link: a one-byte holding register, a count of bytes
// in the current packet and an idle timer.
// Assumes fill is raised only while the register is empty and drain only
// while it is full; commit_take only while commit_req is high.
module lfb_in_lane #(
    parameter int DW        = 8,
    parameter int PKT_BYTES = 512,
    parameter int TW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    input  logic          drain,
    input  logic          commit_take,
    input  logic [TW-1:0] reload_val,
    output logic          hold_v,
    output logic [DW-1:0] hold_d,
    output logic          commit_req
);

    localparam int CW = $clog2(PKT_BYTES);

    logic [CW-1:0] pkt_cnt;
    logic [TW-1:0] idle_tmr;

    // Holding register: take a byte when filled, release it when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (fill) begin
            hold_v <= 1'b1;
            hold_d <= fill_data;
        end else if (drain) begin
            hold_v <= 1'b0;
        end
    end

    // Packet byte count and idle timer: reload on write, clear on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt  <= '0;
            idle_tmr <= '0;
        end else if (drain) begin
            pkt_cnt  <= (pkt_cnt == CW'(PKT_BYTES - 1)) ? '0 : pkt_cnt + 1'b1;
            idle_tmr <= reload_val;
        end else if (commit_take) begin
            pkt_cnt  <= '0;
        end else if (idle_tmr != '0) begin
            idle_tmr <= idle_tmr - 1'b1;
        end
    end

    // A partly filled packet whose timer has expired wants a commit.
    assign commit_req = (pkt_cnt != '0) && (idle_tmr == '0);

endmodule

// File: rtl/link_fifo_bridge.sv
// Bridge between two byte-stream link ports and a four-buffer slave FIFO.
// Addresses 0/1 are the outbound buffers of links 0/1, addresses 2/3 the
// inbound ones. One buffer is served per cycle, round-robin. Outbound data
// reaches the link transmitter (direct), its own inbound buffer (loopback)
// or the other link's inbound buffer (crossback). Partly filled inbound
// packets are committed after an idle time scaled by link_speed.
// Assumes fifo_rdata shows the head byte of the addressed buffer in the
// cycle fifo_rd is raised, and that route_mode changes only when idle.
module link_fifo_bridge
    import lfb_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PKT_BYTES = 512,
    parameter int BIT_TIMES = 16,
    parameter int SLOW_DIV  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      route_mode,
    input  logic [1:0]      link_speed,
    output logic [1:0]      fifo_addr,
    output logic            fifo_rd,
    input  logic [DW-1:0]   fifo_rdata,
    input  logic [1:0]      flag_empty,
    input  logic [1:0]      flag_full,
    output logic            fifo_wr,
    output logic [DW-1:0]   fifo_wdata,
    output logic            fifo_commit,
    output logic [1:0]      tx_valid,
    output logic [2*DW-1:0] tx_data,
    input  logic [1:0]      tx_ready,
    input  logic [1:0]      rx_valid,
    input  logic [2*DW-1:0] rx_data,
    output logic [1:0]      rx_ready
);

    localparam int NL         = 2;
    localparam int NA         = 2 * NL;
    localparam int AW         = $clog2(NA);
    localparam int RELOAD_MAX = BIT_TIMES * SLOW_DIV;
    localparam int TW         = $clog2(RELOAD_MAX + 1);

    path_e          path;
    logic [NA-1:0]  elig;
    logic           any;
    logic [AW-1:0]  pick;
    logic [AW-1:0]  rr_ptr;
    logic           sel;
    logic [TW-1:0]  reload_val;
    logic [NL-1:0]  dest_free;
    logic [NL-1:0]  tx_v;
    logic [DW-1:0]  tx_d [NL];
    logic [NL-1:0]  in_v;
    logic [DW-1:0]  in_d [NL];
    logic [NL-1:0]  creq;
    logic [NL-1:0]  fill;
    logic [DW-1:0]  fill_d [NL];

    assign path       = decode_route(route_mode);
    assign reload_val = TW'(RELOAD_MAX) >> link_speed;
    assign sel        = pick[0];

    lfb_rr_pick #(.N(NA), .AW(AW)) i_pick (
        .req  (elig),
        .ptr  (rr_ptr),
        .any  (any),
        .pick (pick)
    );

    // Strobes for the chosen buffer; a commit uses an inbound slot with no byte to write.
    assign fifo_rd     = any && !pick[1];
    assign fifo_wr     = any && pick[1] && in_v[sel] && !flag_full[sel];
    assign fifo_commit = any && pick[1] && !fifo_wr;
    assign fifo_addr   = any ? pick : '0;
    assign fifo_wdata  = in_d[sel];

    // Round-robin pointer: move one past the address just served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (any)
            rr_ptr <= pick + 1'b1;
    end

    for (genvar k = 0; k < NL; k++) begin : g_link
        localparam int PEER = NL - 1 - k;

        // Is the register that would receive link k's outbound byte free?
        always_comb begin
            case (path)
                PATH_DIRECT: dest_free[k] = !tx_v[k];
                PATH_LOOP:   dest_free[k] = !in_v[k];
                default:     dest_free[k] = !in_v[PEER];
            endcase
        end

        assign elig[k]      = !flag_empty[k] && dest_free[k];
        assign elig[NL + k] = (in_v[k] && !flag_full[k]) || creq[k];

        // Transmit holding register: load in direct mode, clear on handshake.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_v[k] <= 1'b0;
                tx_d[k] <= '0;
            end else if (fifo_rd && sel == 1'(k) && path == PATH_DIRECT) begin
                tx_v[k] <= 1'b1;
                tx_d[k] <= fifo_rdata;
            end else if (tx_v[k] && tx_ready[k]) begin
                tx_v[k] <= 1'b0;
            end
        end

        assign tx_valid[k]          = tx_v[k];
        assign tx_data[k*DW +: DW]  = tx_d[k];
        assign rx_ready[k]          = (path == PATH_DIRECT) && !in_v[k];

        // Inbound source: the link receiver, or an outbound byte routed inside.
        always_comb begin
            case (path)
                PATH_DIRECT: begin
                    fill[k]   = rx_valid[k] && rx_ready[k];
                    fill_d[k] = rx_data[k*DW +: DW];
                end
                PATH_LOOP: begin
                    fill[k]   = fifo_rd && sel == 1'(k);
                    fill_d[k] = fifo_rdata;
                end
                default: begin
                    fill[k]   = fifo_rd && sel == 1'(PEER);
                    fill_d[k] = fifo_rdata;
                end
            endcase
        end

        lfb_in_lane #(.DW(DW), .PKT_BYTES(PKT_BYTES), .TW(TW)) i_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .fill        (fill[k]),
            .fill_data   (fill_d[k]),
            .drain       (fifo_wr && sel == 1'(k)),
            .commit_take (fifo_commit && sel == 1'(k)),
            .reload_val  (reload_val),
            .hold_v      (in_v[k]),
            .hold_d      (in_d[k]),
            .commit_req  (creq[k])
        );
    end

endmodule

// File: rtl/lfb_checker.sv
// Protocol checker for link_fifo_bridge, watching only its ports.
// Keeps its own byte count per inbound packet to judge commits.
module lfb_checker #(
    parameter int DW        = 8,
    parameter int PKT_BYTES = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      route_mode,
    input logic [1:0]      fifo_addr,
    input logic            fifo_rd,
    input logic [1:0]      flag_empty,
    input logic [1:0]      flag_full,
    input logic            fifo_wr,
    input logic            fifo_commit,
    input logic [1:0]      tx_valid,
    input logic [2*DW-1:0] tx_data,
    input logic [1:0]      tx_ready,
    input logic [1:0]      rx_ready
);

    localparam int CW = $clog2(PKT_BYTES);

    logic [CW-1:0] seen0, seen1;

    // Independent per-link byte count since the last commit or full packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen0 <= '0;
            seen1 <= '0;
        end else if (fifo_wr) begin
            if (fifo_addr[0])
                seen1 <= (seen1 == CW'(PKT_BYTES - 1)) ? '0 : seen1 + 1'b1;
            else
                seen0 <= (seen0 == CW'(PKT_BYTES - 1)) ? '0 : seen0 + 1'b1;
        end else if (fifo_commit) begin
            if (fifo_addr[0])
                seen1 <= '0;
            else
                seen0 <= '0;
        end
    end

    a_r2_read_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (!fifo_addr[1] && !flag_empty[fifo_addr[0]]));

    a_r3_write_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_addr[1] && !flag_full[fifo_addr[0]]));

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fifo_rd, fifo_wr, fifo_commit}) <= 1);

    a_r5_tx0_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid[0] && !tx_ready[0]) |=> (tx_valid[0] && $stable(tx_data[DW-1:0])));

    a_r5_tx1_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid[1] && !tx_ready[1]) |=> (tx_valid[1] && $stable(tx_data[2*DW-1:DW])));

    a_r8_rx_closed_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (route_mode != 2'b00) |-> (rx_ready == 2'b00));

    a_r11_commit_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_commit |-> (fifo_addr[1] && ((fifo_addr[0] ? seen1 : seen0) != '0)));

endmodule

bind link_fifo_bridge lfb_checker #(.DW(DW), .PKT_BYTES(PKT_BYTES)) i_lfb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .route_mode  (route_mode),
    .fifo_addr   (fifo_addr),
    .fifo_rd     (fifo_rd),
    .flag_empty  (flag_empty),
    .flag_full   (flag_full),
    .fifo_wr     (fifo_wr),
    .fifo_commit (fifo_commit),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready),
    .rx_ready    (rx_ready)
);

// File: tb/test_link_fifo_bridge.sv
// Bench for link_fifo_bridge: a behavioural reference model compared every cycle,
// plus end-of-phase checks on delivered byte streams and commit counts.
module test_link_fifo_bridge;

    localparam int DW = 8;
    localparam int PKT = 8;
    localparam int BT = 4;
    localparam int SD = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      route_mode = 2'b00;
    logic [1:0]      link_speed = 2'b00;
    logic [1:0]      fifo_addr;
    logic            fifo_rd;
    logic [DW-1:0]   fifo_rdata = '0;
    logic [1:0]      flag_empty = 2'b11;
    logic [1:0]      flag_full = 2'b00;
    logic            fifo_wr;
    logic [DW-1:0]   fifo_wdata;
    logic            fifo_commit;
    logic [1:0]      tx_valid;
    logic [2*DW-1:0] tx_data;
    logic [1:0]      tx_ready = 2'b00;
    logic [1:0]      rx_valid = 2'b00;
    logic [2*DW-1:0] rx_data = '0;
    logic [1:0]      rx_ready;

    always #4 clk = ~clk;

    link_fifo_bridge #(.DW(DW), .PKT_BYTES(PKT), .BIT_TIMES(BT), .SLOW_DIV(SD)) i_link_fifo_bridge (
        .clk(clk), .rst_n(rst_n), .route_mode(route_mode), .link_speed(link_speed),
        .fifo_addr(fifo_addr), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
        .flag_empty(flag_empty), .flag_full(flag_full), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .fifo_commit(fifo_commit), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int phase = 0;
    bit done = 0;

    // stimulus and capture queues
    int oq0[$], oq1[$], rq0[$], rq1[$];
    int cap0[$], cap1[$], txc0[$], txc1[$];
    int ex0[$], ex1[$];
    int commits[2];

    // reference model state
    int m_rr;
    bit m_txv[2];
    int m_txd[2];
    bit m_inv[2];
    int m_ind[2];
    int m_cnt[2];
    int m_tmr[2];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit same_q(input int a[$], input int b[$]);
        if (a.size() != b.size()) return 0;
        foreach (a[i]) if (a[i] != b[i]) return 0;
        return 1;
    endfunction

    task automatic step();
        bit req[2];
        bit el[4];
        bit dfree;
        bit rxr[2];
        bit acc_rx[2];
        bit acc_tx[2];
        bit e_rd, e_wr, e_cm;
        int g, k, b, e_addr, rel;
        @(negedge clk);
        cyc++;
        flag_empty = {oq1.size() == 0, oq0.size() == 0};
        flag_full  = (phase == 2) ? {(cyc % 5) == 1, (cyc % 7) == 3} : 2'b00;
        tx_ready   = {(cyc % 3) != 0, (cyc % 2) == 0};
        rx_valid   = {rq1.size() != 0, rq0.size() != 0};
        rx_data    = {8'(rq1.size() != 0 ? rq1[0] : 0), 8'(rq0.size() != 0 ? rq0[0] : 0)};
        rel = (BT * SD) >> link_speed;
        for (int i = 0; i < 2; i++) begin
            req[i] = (m_cnt[i] != 0) && (m_tmr[i] == 0);
            if (route_mode == 2'b00)      dfree = !m_txv[i];
            else if (route_mode == 2'b01) dfree = !m_inv[i];
            else                          dfree = !m_inv[1 - i];
            el[i]     = !flag_empty[i] && dfree;
            el[2 + i] = (m_inv[i] && !flag_full[i]) || req[i];
            rxr[i]    = (route_mode == 2'b00) && !m_inv[i];
            acc_rx[i] = rx_valid[i] && rxr[i];
            acc_tx[i] = m_txv[i] && tx_ready[i];
        end
        g = -1;
        for (int i = 0; i < 4; i++) if (g < 0 && el[(m_rr + i) % 4]) g = (m_rr + i) % 4;
        e_rd = (g >= 0) && (g < 2);
        e_wr = (g >= 2) && m_inv[g - 2] && !flag_full[g - 2];
        e_cm = (g >= 2) && !e_wr;
        e_addr = (g < 0) ? 0 : g;
        fifo_rdata = e_rd ? 8'(g == 0 ? oq0[0] : oq1[0]) : 8'h00;
        #1;
        chk(fifo_addr == 2'(e_addr), "R4 round-robin address", fifo_addr, e_addr);
        chk(fifo_rd == e_rd, "R2 read strobe", fifo_rd, e_rd);
        chk(fifo_wr == e_wr, "R3 write strobe", fifo_wr, e_wr);
        if (e_wr) chk(fifo_wdata == 8'(m_ind[g - 2]), "R1 inbound data", fifo_wdata, m_ind[g - 2]);
        chk(fifo_commit == e_cm, "R9 idle commit", fifo_commit, e_cm);
        for (int i = 0; i < 2; i++) begin
            chk(tx_valid[i] == m_txv[i], "R5 tx valid", tx_valid[i], m_txv[i]);
            if (m_txv[i]) chk(tx_data[i*8 +: 8] == 8'(m_txd[i]), "R5 tx data", tx_data[i*8 +: 8], m_txd[i]);
            chk(rx_ready[i] == rxr[i], "R8 rx ready", rx_ready[i], rxr[i]);
        end
        // capture what the design put out
        if (fifo_wr) begin
            if (fifo_addr[0]) cap1.push_back(fifo_wdata); else cap0.push_back(fifo_wdata);
        end
        if (fifo_commit) commits[fifo_addr[0]]++;
        if (tx_valid[0] && tx_ready[0]) txc0.push_back(tx_data[7:0]);
        if (tx_valid[1] && tx_ready[1]) txc1.push_back(tx_data[15:8]);
        @(posedge clk);
        for (int i = 0; i < 2; i++) if (acc_tx[i]) m_txv[i] = 0;
        if (e_rd) begin
            k = g;
            if (k == 0) b = oq0.pop_front(); else b = oq1.pop_front();
            if (route_mode == 2'b00)      begin m_txv[k] = 1; m_txd[k] = b; end
            else if (route_mode == 2'b01) begin m_inv[k] = 1; m_ind[k] = b; end
            else                          begin m_inv[1 - k] = 1; m_ind[1 - k] = b; end
        end
        for (int i = 0; i < 2; i++) begin
            if (e_wr && g - 2 == i) begin
                m_inv[i] = 0;
                m_cnt[i] = (m_cnt[i] + 1) % PKT;
                m_tmr[i] = rel;
            end else if (e_cm && g - 2 == i) begin
                m_cnt[i] = 0;
            end else if (m_tmr[i] > 0) begin
                m_tmr[i]--;
            end
        end
        if (acc_rx[0]) begin m_inv[0] = 1; m_ind[0] = rq0.pop_front(); end
        if (acc_rx[1]) begin m_inv[1] = 1; m_ind[1] = rq1.pop_front(); end
        if (g >= 0) m_rr = (g + 1) % 4;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_caps();
        cap0.delete(); cap1.delete(); txc0.delete(); txc1.delete();
        commits[0] = 0; commits[1] = 0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        int c0, c1;
        m_rr = 0;
        for (int i = 0; i < 2; i++) begin
            m_txv[i] = 0; m_txd[i] = 0; m_inv[i] = 0; m_ind[i] = 0; m_cnt[i] = 0; m_tmr[i] = 0;
        end
        clear_caps();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk({fifo_rd, fifo_wr, fifo_commit} == 3'b000, "R4 reset strobes", {fifo_rd, fifo_wr, fifo_commit}, 0);
        chk(tx_valid == 2'b00, "R5 reset tx_valid", tx_valid, 0);
        chk(rx_ready == 2'b11, "R8 reset rx_ready", rx_ready, 3);
        chk(fifo_addr == 2'b00, "R1 reset address", fifo_addr, 0);
        rst_n = 1'b1;

        // direct mode, slowest speed, irregular ready and full flags
        phase = 2; route_mode = 2'b00; link_speed = 2'd0;
        oq0 = '{8'h11, 8'h12, 8'h13}; oq1 = '{8'h21, 8'h22};
        rq0 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35}; rq1 = '{8'h41, 8'h42, 8'h43};
        run(200);
        ex0 = '{8'h11, 8'h12, 8'h13}; ex1 = '{8'h21, 8'h22};
        chk(same_q(txc0, ex0), "R5 link0 transmit stream", txc0.size(), ex0.size());
        chk(same_q(txc1, ex1), "R5 link1 transmit stream", txc1.size(), ex1.size());
        ex0 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35}; ex1 = '{8'h41, 8'h42, 8'h43};
        chk(same_q(cap0, ex0), "R8 link0 receive stream", cap0.size(), ex0.size());
        chk(same_q(cap1, ex1), "R8 link1 receive stream", cap1.size(), ex1.size());
        chk(commits[0] == 1, "R9 link0 one idle commit", commits[0], 1);
        chk(commits[1] == 1, "R9 link1 one idle commit", commits[1], 1);

        // loopback; the receiver byte must stay untouched
        phase = 3; route_mode = 2'b01; link_speed = 2'd1;
        clear_caps();
        rq0 = '{8'h99};
        run(60);
        chk(commits[0] + commits[1] == 0, "R11 no commit without data", commits[0] + commits[1], 0);
        chk(rq0.size() == 1 && cap0.size() == 0, "R8 receiver ignored in loopback", rq0.size(), 1);
        oq0 = '{8'h51, 8'h52, 8'h53, 8'h54};
        oq1 = '{8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'h67, 8'h68};
        ex0 = oq0; ex1 = oq1;
        run(200);
        chk(same_q(cap0, ex0), "R6 link0 loopback stream", cap0.size(), ex0.size());
        chk(same_q(cap1, ex1), "R6 link1 loopback stream", cap1.size(), ex1.size());
        chk(commits[0] == 1, "R9 loopback partial packet commit", commits[0], 1);
        chk(commits[1] == 0, "R10 full packet gets no commit", commits[1], 0);
        chk(txc0.size() + txc1.size() == 0, "R6 nothing transmitted in loopback", txc0.size() + txc1.size(), 0);

        // crossback at the fastest setting
        phase = 4; route_mode = 2'b10; link_speed = 2'd3;
        clear_caps();
        oq0 = '{8'h71, 8'h72, 8'h73}; oq1 = '{8'h81, 8'h82};
        ex1 = oq0; ex0 = oq1;
        run(100);
        chk(same_q(cap1, ex1), "R7 link0 out to link1 in", cap1.size(), ex1.size());
        chk(same_q(cap0, ex0), "R7 link1 out to link0 in", cap0.size(), ex0.size());
        c0 = commits[0]; c1 = commits[1];
        chk(c0 >= 1 && c1 >= 1, "R9 crossback commits", c0 + c1, 2);
        chk(rq0.size() == 1, "R8 receiver ignored in crossback", rq0.size(), 1);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule